// File: doc/BRIEF.md
# Link Port Receiver with Early-Warning Flow Control

The block terminates a byte-wide, source-synchronous link. The far end drives a link clock and eight data lines. The receiver samples each byte on a falling edge of that clock and packs four consecutive bytes into a 32-bit word, starting with the least significant byte. Each finished word goes into a two-entry buffer whose read side runs on the core clock. The core takes words through a valid/ready handshake.

Back-pressure goes to the sender on a single acknowledge line. The receiver holds that line high unless the buffer is really about to run out of space. When one entry is already occupied and the next word has begun to arrive, the line drops after the rising link-clock edge that follows the first byte. That gives the sender one word of warning, so it finishes the word in progress and then pauses. The line is also low while the buffer is full.

An enable input from the core turns the port on and off, and it acts on the second core clock edge after it changes. While the port is off, the acknowledge line is held low, any partly assembled word is discarded, and words already buffered are hidden from the core but kept.

Top module: `link_rx`

## Requirements
- R1: `ldat_i` is sampled only on falling edges of `lclk_i`, one 8-bit unit per falling edge.
- R2: Four consecutive units form one word; the first unit lands in bits 7:0 and the fourth in bits 31:24.
- R3: Words are presented on `word_o` with `valid_o` high in arrival order. A word leaves on a core edge where `valid_o` and `ready_i` are both high. `word_o` and `valid_o` hold steady while `ready_i` is low.
- R4: With the buffer empty, `lack_o` stays high while a word is being assembled.
- R5: With one word stored, `lack_o` stays high until the first unit of the next word has arrived. It falls after the rising `lclk_i` edge that follows that unit.
- R6: `lack_o` is low while the buffer holds its full two words.
- R7: Once the core reads a word so that the buffer holds fewer than two, `lack_o` returns high if no word is in progress.
- R8: A change on `en_i` takes effect on `lack_o` and `valid_o` on the second rising `clk_i` edge after it, and not on the first.
- R9: While disabled, `lack_o` is low and the partial-word state is cleared, so a new word after re-enable assembles from its own first unit.
- R10: While disabled, `valid_o` is low and `ready_i` has no effect. Stored words are presented again after re-enable.
- R11: A sender that starts a word only while `lack_o` is high never causes a stored word to be lost or overwritten.
- R12: The write pointer crosses into the core domain Gray-coded, changing at most one bit per core cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Port enable, core domain |
| lclk_i | input | 1 | Link clock from the sender, idles high |
| ldat_i | input | 8 | Link data, sampled on falling `lclk_i` |
| lack_o | output | 1 | Acknowledge to the sender, low means pause after the current word |
| word_o | output | 32 | Received word |
| valid_o | output | 1 | `word_o` holds a word |
| ready_i | input | 1 | Core accepts `word_o` |

## Verification
The assertions assume three things about the sender:
- It begins a word only while `lack_o` is high.
- It keeps `lclk_i` high when idle and does not toggle it while the port is disabled.
- Each half period of `lclk_i` spans at least four core cycles, so the synchronized occupancy settles before the next link edge.

They also assume `en_i` is low during reset. The stimulus keeps within these limits in the following ways:
- Its sender model idles the link clock high and uses half periods of five core cycles.
- It checks `lack_o` before each word.
- It toggles the enable only with the link clock at rest.

The sweep runs a reader that alternates bursts of acceptance with long pauses. This drives the buffer through the empty, one-entry and full states many times.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  localparam int unsigned UNIT_W = 8;
  typedef logic [UNIT_W-1:0] unit_t;
endpackage

// File: rtl/lrx_en_pipe.sv
module lrx_en_pipe #(
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic port_on_o
);
  logic [LAT-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAT-2:0], en_i};
  end

  assign port_on_o = sh_q[LAT-1];

  generate
    if (LAT == 2) begin : g_lat_chk
      // R8
      en_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(rst_ni, 2)) |-> (port_on_o == $past(en_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/lrx_assembler.sv
module lrx_assembler
  import lrx_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         lclk_i,
  input  logic         lrst_ni,
  input  unit_t        ldat_i,
  output logic         wr_o,
  output logic [W-1:0] wdata_o,
  output logic         busy_o
);
  localparam int unsigned LANES = W / UNIT_W;
  localparam int unsigned CW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned SW    = W - UNIT_W;

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] shreg_q;
  logic          last;
  logic          busy_q;

  assign last = (cnt_q == CW'(LANES - 1));

  // unit counter advances on every falling link edge
  always_ff @(negedge lclk_i or negedge lrst_ni) begin
    if (!lrst_ni)  cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end

  generate
    if (LANES > 2) begin : g_shift_wide
      always_ff @(negedge lclk_i or negedge lrst_ni) begin
        if (!lrst_ni) shreg_q <= '0;
        else          shreg_q <= {ldat_i, shreg_q[SW-1:UNIT_W]};
      end
    end else begin : g_shift_one
      always_ff @(negedge lclk_i or negedge lrst_ni) begin
        if (!lrst_ni) shreg_q <= '0;
        else          shreg_q <= ldat_i;
      end
    end
  endgenerate

  // word-in-progress flag, timed from the rising link edge
  always_ff @(posedge lclk_i or negedge lrst_ni) begin
    if (!lrst_ni) busy_q <= 1'b0;
    else          busy_q <= (cnt_q != '0);
  end

  assign wr_o    = last;
  assign wdata_o = {ldat_i, shreg_q};
  assign busy_o  = busy_q;
endmodule

// File: rtl/lrx_cdc_fifo.sv
module lrx_cdc_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic            wclk_i,
  input  logic            wrst_ni,
  input  logic            wr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            rclk_i,
  input  logic            rrst_ni,
  input  logic            rd_i,
  output logic [W-1:0]    rdata_o,
  output logic            empty_o,
  output logic [$clog2(DEPTH):0] count_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, wbin_n;
  logic [PW-1:0] wg_s1_q, wg_s2_q, wbin_s;
  logic [PW-1:0] rbin_q;

  // write side, falling link edge
  assign wbin_n = wbin_q + PW'(wr_i);

  always_ff @(negedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= to_gray(wbin_n);
    end
  end

  always_ff @(negedge wclk_i) begin
    if (wr_i) mem_q[wbin_q[AW-1:0]] <= wdata_i;
  end

  // read side, core clock
  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      wg_s1_q <= '0;
      wg_s2_q <= '0;
      rbin_q  <= '0;
    end else begin
      wg_s1_q <= wgray_q;
      wg_s2_q <= wg_s1_q;
      rbin_q  <= rbin_q + PW'(rd_i);
    end
  end

  assign wbin_s  = from_gray(wg_s2_q);
  assign count_o = wbin_s - rbin_q;
  assign empty_o = (count_o == '0);
  assign rdata_o = mem_q[rbin_q[AW-1:0]];

  // R12
  gray_step_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $onehot0(wg_s2_q ^ $past(wg_s2_q)));

  // R11
  no_overflow_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    count_o <= PW'(DEPTH));
endmodule

// File: rtl/link_rx.sv
module link_rx
  import lrx_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned EN_LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         lclk_i,
  input  logic [7:0]   ldat_i,
  output logic         lack_o,
  output logic [W-1:0] word_o,
  output logic         valid_o,
  input  logic         ready_i
);
  localparam int unsigned PW = $clog2(DEPTH) + 1;

  logic          port_on;
  logic          lrst_n;
  logic          asm_wr;
  logic [W-1:0]  asm_data;
  logic          asm_busy;
  logic [W-1:0]  rdata;
  logic          empty;
  logic [PW-1:0] count;
  logic          pop;
  logic          near_q, full_q;

  lrx_en_pipe #(.LAT(EN_LAT)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .port_on_o (port_on)
  );

  // link-side state is held clear while the port is off
  assign lrst_n = rst_ni & port_on;

  lrx_assembler #(.W(W)) u_asm (
    .lclk_i  (lclk_i),
    .lrst_ni (lrst_n),
    .ldat_i  (unit_t'(ldat_i)),
    .wr_o    (asm_wr),
    .wdata_o (asm_data),
    .busy_o  (asm_busy)
  );

  lrx_cdc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .wclk_i  (lclk_i),
    .wrst_ni (rst_ni),
    .wr_i    (asm_wr),
    .wdata_i (asm_data),
    .rclk_i  (clk_i),
    .rrst_ni (rst_ni),
    .rd_i    (pop),
    .rdata_o (rdata),
    .empty_o (empty),
    .count_o (count)
  );

  // registered occupancy thresholds keep lack_o glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      near_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      near_q <= (count >= PW'(DEPTH - 1));
      full_q <= (count == PW'(DEPTH));
    end
  end

  assign lack_o  = port_on & ~((asm_busy & near_q) | full_q);
  assign valid_o = port_on & ~empty;
  assign pop     = valid_o & ready_i;
  assign word_o  = rdata;

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && port_on) |=> (!port_on || (valid_o && $stable(word_o))));
endmodule

// File: tb/link_rx_test.sv
`timescale 1ns/1ps
module link_rx_test;
  localparam int HP = 20;
  localparam int NW = 48;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        lclk_i = 1'b1;
  logic [7:0]  ldat_i = '0;
  logic        lack_o;
  logic [31:0] word_o;
  logic        valid_o;
  logic        ready_i = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  link_rx uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .lclk_i  (lclk_i),
    .ldat_i  (ldat_i),
    .lack_o  (lack_o),
    .word_o  (word_o),
    .valid_o (valid_o),
    .ready_i (ready_i)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'h0103_0507 * (i + 1)) ^ 32'hC3A5_0F96 ^ (i << 13);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_unit(input logic [7:0] b);
    ldat_i = b;
    #(HP) lclk_i = 1'b0;
    #(HP) lclk_i = 1'b1;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) send_unit(w[8*k +: 8]);
  endtask

  task automatic pop_one();
    @(negedge clk_i) ready_i = 1'b1;
    @(negedge clk_i) ready_i = 1'b0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      report();
    end
  end

  initial begin
    logic [31:0] wa, wb, wc, wd;
    wa = 32'h4433_2211;
    wb = 32'hA1B2_C3D4;
    wc = 32'h0F1E_2D3C;
    wd = 32'h8899_AABB;

    settle(4);
    rst_ni = 1'b1;
    settle(2);
    chk("R9 reset lack", {31'b0, lack_o}, 32'd0);
    chk("R10 reset valid", {31'b0, valid_o}, 32'd0);

    // R8: second core edge after the change
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R8 first edge", {31'b0, lack_o}, 32'd0);
    @(negedge clk_i);
    chk("R8 second edge", {31'b0, lack_o}, 32'd1);

    // R4: empty buffer, word in progress
    send_unit(wa[7:0]);
    #(HP/2);
    chk("R4 lack during word", {31'b0, lack_o}, 32'd1);
    for (int k = 1; k < 4; k++) send_unit(wa[8*k +: 8]);
    settle(6);
    chk("R3 valid", {31'b0, valid_o}, 32'd1);
    chk("R1 R2 word order", word_o, wa);

    // R5: one stored, drop only after first unit
    chk("R5 lack before unit", {31'b0, lack_o}, 32'd1);
    send_unit(wb[7:0]);
    #(HP/2);
    chk("R5 lack after first unit", {31'b0, lack_o}, 32'd0);
    for (int k = 1; k < 4; k++) send_unit(wb[8*k +: 8]);
    settle(6);
    chk("R6 lack when full", {31'b0, lack_o}, 32'd0);
    chk("R3 head held", word_o, wa);

    pop_one();
    settle(3);
    chk("R3 second word", word_o, wb);
    chk("R7 lack after drain", {31'b0, lack_o}, 32'd1);
    pop_one();
    settle(2);
    chk("R3 empty", {31'b0, valid_o}, 32'd0);

    // R10: stored word survives disable, ready ignored
    send_word(wc);
    settle(6);
    @(negedge clk_i) en_i = 1'b0;
    settle(3);
    chk("R10 valid off", {31'b0, valid_o}, 32'd0);
    chk("R9 lack off", {31'b0, lack_o}, 32'd0);
    @(negedge clk_i) ready_i = 1'b1;
    settle(3);
    ready_i = 1'b0;
    en_i = 1'b1;
    settle(3);
    chk("R10 valid back", {31'b0, valid_o}, 32'd1);
    chk("R10 word kept", word_o, wc);
    pop_one();
    settle(2);

    // R9: partial word discarded by disable
    send_unit(8'hEE);
    send_unit(8'hDD);
    @(negedge clk_i) en_i = 1'b0;
    settle(3);
    chk("R9 lack low mid word", {31'b0, lack_o}, 32'd0);
    en_i = 1'b1;
    settle(3);
    send_word(wd);
    settle(6);
    chk("R9 fresh word", word_o, wd);
    pop_one();
    settle(2);
    chk("R9 single word", {31'b0, valid_o}, 32'd0);

    // sweep: sender obeys lack, reader pauses to fill the buffer
    fork
      begin
        for (int i = 0; i < NW; i++) begin
          @(negedge clk_i);
          while (!lack_o) @(negedge clk_i);
          send_word(pat(i));
        end
      end
      begin
        int rd = 0;
        int cyc = 0;
        while (rd < NW) begin
          @(negedge clk_i);
          cyc++;
          if (valid_o && ((cyc % 97) >= 60)) begin
            chk($sformatf("R3 R11 R12 sweep word %0d", rd), word_o, pat(rd));
            rd++;
            ready_i = 1'b1;
          end else begin
            ready_i = 1'b0;
          end
        end
        @(negedge clk_i) ready_i = 1'b0;
      end
    join
    settle(4);
    chk("R11 drained", {31'b0, valid_o}, 32'd0);

    if (!done) begin
      done = 1'b1;
      report();
    end
  end
endmodule